// File: doc/BRIEF.md
# E1 Transmit Frame Formatter

This block paces a 2.048 Mb/s E1 transmit stream one bit per clock. It keeps the bit, timeslot, frame and 16-frame multiframe position. It merges a payload bit stream with the overhead that the frame structure calls for. Overhead covers the frame alignment word, the international and national bits, the multiframe alignment nibble and the extra bits of the signalling timeslot. It also forces patterns for alarm and idle conditions. Beside the formatted NRZ bit it drives four timing strobes: a timeslot clock, a signalling-timeslot flag, an alignment-frame flag and a multiframe marker. These strobes tell upstream logic which bit is being consumed.

The payload path is a fixed-rate TDM stream, so it has no valid/ready handshake and no back-pressure. Every serial input is consumed in the clock cycle that holds its bit position, whether or not it is used. A source that cannot keep pace must buffer upstream. The frame and multiframe sync inputs are optional. Holding both low lets the counters run free from reset. A rising edge on either one re-aligns the counters in the cycle where the edge is seen. Each overhead field takes its source from a serial input or from a static configuration field, chosen by its own select pin.

Top module: `e1_tx_framer`

## Requirements
- R1: While `rst` is high, all outputs are 0 and the position returns to frame 0, timeslot 0, bit 1. The first output after release is that position: `mf_start`=1, `slot_clk`=1, `sig_slot`=0, and `align_frame`=1 when `mf_on_nonalign`=0.
- R2: A frame is 256 clocks (32 timeslots of 8 bits). `slot_clk` is high for bits 1-4 and low for bits 5-8 of every timeslot, so it is high 128 cycles per frame.
- R3: `sig_slot` is high exactly during the 8 bits of timeslot 16 in every frame.
- R4: `mf_start` is high during frame 0 of the 16-frame multiframe only (256 cycles per multiframe). `align_frame` is high in every other frame (2048 cycles per multiframe).
- R5: With `mf_on_nonalign`=0, frame 0 is an alignment frame. With `mf_on_nonalign`=1, frame 0 is a non-alignment frame and the odd frames carry the alignment word.
- R6: In alignment frames, bits 2-8 of timeslot 0 carry 0011011 (bit 2 first). In non-alignment frames, bit 2 is 1 and bit 3 is 0.
- R7: Bit 1 of timeslot 0 of every frame is `natint_in` when `sel_intl_reg`=0, and `cfg_intl_reg` when `sel_intl_reg`=1.
- R8: Bits 4-8 of timeslot 0 in non-alignment frames are `natint_in` when `sel_nat_reg`=0. When `sel_nat_reg`=1 they are `cfg_nat_reg[4]` (bit 4) down to `cfg_nat_reg[0]` (bit 8). Alignment frames never carry national bits.
- R9: In signalling-associated mode (`ccs_mode`=0), timeslot 16 of frame 0 carries 0000 in bits 1-4 and the payload bit in bit 6. Bits 5, 7 and 8 carry `xbit_in` when `sel_xbit_reg`=0, or `cfg_xbit_reg[0]`, `[1]` and `[2]` respectively when it is 1.
- R10: In timeslot 16 of frames 1-15, with `ccs_mode`=0, the bit is `sig_in` when `sel_sig_port`=1 and `ser_in` otherwise. With `ccs_mode`=1, all of timeslot 16 in every frame is `ser_in` and `sig_in` has no effect.
- R11: `ts16_ones`=1 drives every bit of timeslot 16 in every frame to 1.
- R12: `unframed_ones`=1 drives every output bit to 1, overriding all overhead and payload.
- R13: A rising edge on `fsync_in` makes the current cycle bit 1 of timeslot 0. The frame number holds if the counters were already there, and advances by one otherwise. A rising edge on `mfsync_in` makes the current cycle frame 0, timeslot 0, bit 1, and it wins when both edges coincide.
- R14: All other bit positions carry `ser_in`. Every output reflects the inputs and position of the previous clock cycle (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| fsync_in | input | 1 | Frame sync, rising edge marks timeslot 0 bit 1 |
| mfsync_in | input | 1 | Multiframe sync, rising edge marks frame 0 |
| ser_in | input | 1 | NRZ payload bit |
| sig_in | input | 1 | Separate signalling bit for timeslot 16 |
| xbit_in | input | 1 | Serial extra-bit source |
| natint_in | input | 1 | Serial international/national bit source |
| cfg_intl_reg | input | 1 | Static international bit |
| cfg_nat_reg | input | 5 | Static national bits, [4] sent first |
| cfg_xbit_reg | input | 3 | Static extra bits for bits 5, 7, 8 |
| sel_intl_reg | input | 1 | International bit from `cfg_intl_reg` |
| sel_nat_reg | input | 1 | National bits from `cfg_nat_reg` |
| sel_xbit_reg | input | 1 | Extra bits from `cfg_xbit_reg` |
| sel_sig_port | input | 1 | Signalling taken from `sig_in` |
| ccs_mode | input | 1 | Common-channel mode: timeslot 16 is payload |
| mf_on_nonalign | input | 1 | Multiframe starts on a non-alignment frame |
| ts16_ones | input | 1 | Force timeslot 16 to all ones |
| unframed_ones | input | 1 | Force the whole stream to ones |
| ser_out | output | 1 | Formatted NRZ bit |
| slot_clk | output | 1 | Timeslot clock, high in bits 1-4 |
| sig_slot | output | 1 | High during timeslot 16 |
| align_frame | output | 1 | High during alignment frames |
| mf_start | output | 1 | High during frame 0 of the multiframe |

## Verification
Two re-alignment functions can act in the same cycle: a frame sync edge and a multiframe sync edge. The bench lets the counters run into the middle of a frame and then raises both sync inputs just before one edge. It expects `mf_start` and `align_frame` high with `slot_clk` high at once, and `sig_slot` rising exactly 128 cycles later. The outcome confirms that the multiframe edge wins and that the frame edge only re-bases the bit count. The same scheme is run with a lone frame sync mid-frame, which should advance to the next frame. Overhead forcing that coincides with field insertion, such as all-ones over the alignment word or over the multiframe nibble, is judged from the table of single-bit vectors.

// File: rtl/e1_tx_pkg.sv
package e1_tx_pkg;

  // Frame geometry of the 2.048 Mb/s stream
  localparam int unsigned NBITS   = 8;
  localparam int unsigned NSLOTS  = 32;
  localparam int unsigned NFRAMES = 16;
  localparam int unsigned SIG_TS  = 16;

  localparam int unsigned BT_W = $clog2(NBITS);
  localparam int unsigned SL_W = $clog2(NSLOTS);
  localparam int unsigned FR_W = $clog2(NFRAMES);

  // Alignment word in bits 2..8, indexed by (NBITS-1 - bit index); bit 7 unused
  localparam logic [NBITS-1:0] FAS_WORD = 8'b0_0011011;

  typedef struct packed {
    logic [FR_W-1:0] frame;
    logic [SL_W-1:0] slot;
    logic [BT_W-1:0] bitn;
  } e1_pos_t;

  typedef struct packed {
    logic       unframed_ones;
    logic       ts16_ones;
    logic       ccs_mode;
    logic       sel_sig_port;
    logic       sel_xbit_reg;
    logic       sel_nat_reg;
    logic       sel_intl_reg;
    logic       mf_on_nonalign;
    logic       intl_reg;
    logic [4:0] nat_reg;
    logic [2:0] xbit_reg;
  } e1_tx_cfg_t;

endpackage

// File: rtl/e1_tx_timing.sv
module e1_tx_timing
  import e1_tx_pkg::*;
#(
  parameter int unsigned BITS   = NBITS,
  parameter int unsigned SLOTS  = NSLOTS,
  parameter int unsigned FRAMES = NFRAMES
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    fsync_in,
  input  logic    mfsync_in,
  output e1_pos_t pos
);

  localparam logic [BT_W-1:0] BIT_LAST   = BT_W'(BITS - 1);
  localparam logic [SL_W-1:0] SLOT_LAST  = SL_W'(SLOTS - 1);
  localparam logic [FR_W-1:0] FRAME_LAST = FR_W'(FRAMES - 1);

  e1_pos_t cnt_q, nxt;
  logic    fs_q, ms_q;
  logic    fs_rise, ms_rise;

  assign fs_rise = fsync_in & ~fs_q;
  assign ms_rise = mfsync_in & ~ms_q;

  function automatic logic [FR_W-1:0] frame_inc(input logic [FR_W-1:0] f);
    return (f == FRAME_LAST) ? '0 : f + 1'b1;
  endfunction

  // Effective position of this cycle after sync overrides
  always_comb begin
    pos = cnt_q;
    if (ms_rise) begin
      pos = '0;
    end else if (fs_rise) begin
      pos.bitn = '0;
      pos.slot = '0;
      if (cnt_q.bitn != '0 || cnt_q.slot != '0)
        pos.frame = frame_inc(cnt_q.frame);
    end
  end

  always_comb begin
    nxt = pos;
    if (pos.bitn == BIT_LAST) begin
      nxt.bitn = '0;
      if (pos.slot == SLOT_LAST) begin
        nxt.slot  = '0;
        nxt.frame = frame_inc(pos.frame);
      end else begin
        nxt.slot = pos.slot + 1'b1;
      end
    end else begin
      nxt.bitn = pos.bitn + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    fs_q <= fsync_in;
    ms_q <= mfsync_in;
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt;
  end

endmodule

// File: rtl/e1_tx_ovh_mux.sv
module e1_tx_ovh_mux
  import e1_tx_pkg::*;
#(
  parameter int unsigned SIG_SLOT = SIG_TS
) (
  input  e1_pos_t    pos,
  input  e1_tx_cfg_t cfg,
  input  logic       ser_in,
  input  logic       sig_in,
  input  logic       xbit_in,
  input  logic       natint_in,
  output logic       align,
  output logic       bit_out
);

  localparam logic [SL_W-1:0] SIG_IDX = SL_W'(SIG_SLOT);

  logic [BT_W-1:0] b;
  logic [BT_W-1:0] rev;

  assign b     = pos.bitn;
  assign rev   = BT_W'(NBITS - 1) - b;
  assign align = ~(pos.frame[0] ^ cfg.mf_on_nonalign);

  always_comb begin
    bit_out = ser_in;
    if (cfg.unframed_ones) begin
      bit_out = 1'b1;
    end else if (pos.slot == '0) begin
      if (b == '0)
        bit_out = cfg.sel_intl_reg ? cfg.intl_reg : natint_in;
      else if (align)
        bit_out = FAS_WORD[rev];
      else if (b == BT_W'(1))
        bit_out = 1'b1;
      else if (b == BT_W'(2))
        bit_out = 1'b0;
      else
        bit_out = cfg.sel_nat_reg ? cfg.nat_reg[rev] : natint_in;
    end else if (pos.slot == SIG_IDX) begin
      if (cfg.ts16_ones) begin
        bit_out = 1'b1;
      end else if (cfg.ccs_mode) begin
        bit_out = ser_in;
      end else if (pos.frame == '0) begin
        case (b)
          BT_W'(4): bit_out = cfg.sel_xbit_reg ? cfg.xbit_reg[0] : xbit_in;
          BT_W'(5): bit_out = ser_in;
          BT_W'(6): bit_out = cfg.sel_xbit_reg ? cfg.xbit_reg[1] : xbit_in;
          BT_W'(7): bit_out = cfg.sel_xbit_reg ? cfg.xbit_reg[2] : xbit_in;
          default:  bit_out = 1'b0;
        endcase
      end else begin
        bit_out = cfg.sel_sig_port ? sig_in : ser_in;
      end
    end
  end

endmodule

// File: rtl/e1_tx_framer.sv
module e1_tx_framer
  import e1_tx_pkg::*;
#(
  parameter int unsigned BITS     = NBITS,
  parameter int unsigned SLOTS    = NSLOTS,
  parameter int unsigned FRAMES   = NFRAMES,
  parameter int unsigned SIG_SLOT = SIG_TS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fsync_in,
  input  logic       mfsync_in,
  input  logic       ser_in,
  input  logic       sig_in,
  input  logic       xbit_in,
  input  logic       natint_in,
  input  logic       cfg_intl_reg,
  input  logic [4:0] cfg_nat_reg,
  input  logic [2:0] cfg_xbit_reg,
  input  logic       sel_intl_reg,
  input  logic       sel_nat_reg,
  input  logic       sel_xbit_reg,
  input  logic       sel_sig_port,
  input  logic       ccs_mode,
  input  logic       mf_on_nonalign,
  input  logic       ts16_ones,
  input  logic       unframed_ones,
  output logic       ser_out,
  output logic       slot_clk,
  output logic       sig_slot,
  output logic       align_frame,
  output logic       mf_start
);

  localparam logic [BT_W-1:0] HALF_SLOT = BT_W'(BITS / 2);
  localparam logic [SL_W-1:0] SIG_IDX   = SL_W'(SIG_SLOT);

  e1_pos_t    pos;
  e1_tx_cfg_t cfg;
  logic       align;
  logic       bit_nxt;

  assign cfg = '{
    unframed_ones:  unframed_ones,
    ts16_ones:      ts16_ones,
    ccs_mode:       ccs_mode,
    sel_sig_port:   sel_sig_port,
    sel_xbit_reg:   sel_xbit_reg,
    sel_nat_reg:    sel_nat_reg,
    sel_intl_reg:   sel_intl_reg,
    mf_on_nonalign: mf_on_nonalign,
    intl_reg:       cfg_intl_reg,
    nat_reg:        cfg_nat_reg,
    xbit_reg:       cfg_xbit_reg
  };

  e1_tx_timing #(
    .BITS  (BITS),
    .SLOTS (SLOTS),
    .FRAMES(FRAMES)
  ) u_timing (
    .clk      (clk),
    .rst      (rst),
    .fsync_in (fsync_in),
    .mfsync_in(mfsync_in),
    .pos      (pos)
  );

  e1_tx_ovh_mux #(
    .SIG_SLOT(SIG_SLOT)
  ) u_mux (
    .pos      (pos),
    .cfg      (cfg),
    .ser_in   (ser_in),
    .sig_in   (sig_in),
    .xbit_in  (xbit_in),
    .natint_in(natint_in),
    .align    (align),
    .bit_out  (bit_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out     <= 1'b0;
      slot_clk    <= 1'b0;
      sig_slot    <= 1'b0;
      align_frame <= 1'b0;
      mf_start    <= 1'b0;
    end else begin
      ser_out     <= bit_nxt;
      slot_clk    <= (pos.bitn < HALF_SLOT);
      sig_slot    <= (pos.slot == SIG_IDX);
      align_frame <= align;
      mf_start    <= (pos.frame == '0);
    end
  end

endmodule

// File: rtl/e1_tx_framer_chk.sv
module e1_tx_framer_chk #(
  parameter int unsigned BITS = 8
) (
  input logic clk,
  input logic rst,
  input logic unframed_ones,
  input logic ts16_ones,
  input logic mf_on_nonalign,
  input logic ser_out,
  input logic slot_clk,
  input logic sig_slot,
  input logic align_frame,
  input logic mf_start
);

  localparam int unsigned RUN_W = $clog2(BITS + 2);

  logic [RUN_W-1:0] sig_run;

  always_ff @(posedge clk) begin
    if (rst)           sig_run <= '0;
    else if (sig_slot) sig_run <= (sig_run == RUN_W'(BITS + 1)) ? sig_run : sig_run + 1'b1;
    else               sig_run <= '0;
  end

  // R12: unframed all-ones reaches the output one cycle later
  assert_unframed_ones_R12: assert property (@(posedge clk) disable iff (rst)
    unframed_ones |=> ser_out);

  // R11: timeslot 16 carries ones while forced
  assert_ts16_forced_R11: assert property (@(posedge clk) disable iff (rst)
    (sig_slot && $past(ts16_ones)) |-> ser_out);

  // R3: signalling strobe never lasts longer than one timeslot
  assert_sig_slot_width_R3: assert property (@(posedge clk) disable iff (rst)
    sig_slot |-> (sig_run < RUN_W'(BITS)));

  // R5: multiframe start frame has the selected alignment type
  assert_mf_align_type_R5: assert property (@(posedge clk) disable iff (rst)
    mf_start |-> (align_frame == !$past(mf_on_nonalign)));

  // R2: a new alignment frame opens at a timeslot boundary outside timeslot 16
  assert_align_at_slot_start_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(align_frame) && ($past(mf_on_nonalign, 1) == $past(mf_on_nonalign, 2)))
      |-> (slot_clk && !sig_slot));

endmodule

bind e1_tx_framer e1_tx_framer_chk #(.BITS(BITS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .unframed_ones (unframed_ones),
  .ts16_ones     (ts16_ones),
  .mf_on_nonalign(mf_on_nonalign),
  .ser_out       (ser_out),
  .slot_clk      (slot_clk),
  .sig_slot      (sig_slot),
  .align_frame   (align_frame),
  .mf_start      (mf_start)
);

// File: tb/sim_e1_tx_framer.sv
`timescale 1ns/1ps
module sim_e1_tx_framer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync_in = 0, mfsync_in = 0;
  logic       ser_in = 0, sig_in = 0, xbit_in = 0, natint_in = 0;
  logic       cfg_intl_reg = 0;
  logic [4:0] cfg_nat_reg = '0;
  logic [2:0] cfg_xbit_reg = '0;
  logic       sel_intl_reg = 0, sel_nat_reg = 0, sel_xbit_reg = 0, sel_sig_port = 0;
  logic       ccs_mode = 0, mf_on_nonalign = 0, ts16_ones = 0, unframed_ones = 0;
  logic       ser_out, slot_clk, sig_slot, align_frame, mf_start;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  e1_tx_framer u0 (
    .clk(clk), .rst(rst), .fsync_in(fsync_in), .mfsync_in(mfsync_in),
    .ser_in(ser_in), .sig_in(sig_in), .xbit_in(xbit_in), .natint_in(natint_in),
    .cfg_intl_reg(cfg_intl_reg), .cfg_nat_reg(cfg_nat_reg), .cfg_xbit_reg(cfg_xbit_reg),
    .sel_intl_reg(sel_intl_reg), .sel_nat_reg(sel_nat_reg), .sel_xbit_reg(sel_xbit_reg),
    .sel_sig_port(sel_sig_port), .ccs_mode(ccs_mode), .mf_on_nonalign(mf_on_nonalign),
    .ts16_ones(ts16_ones), .unframed_ones(unframed_ones),
    .ser_out(ser_out), .slot_clk(slot_clk), .sig_slot(sig_slot),
    .align_frame(align_frame), .mf_start(mf_start)
  );

  // [37:34] req | [33:26] cfg {unframed,ts16,ccs,sel_sig,sel_x,sel_nat,sel_intl,mf_nonalign}
  // [25:22] {ser,sig,x,natint} | [21:13] {intl, nat[4:0], x[2:0]} | [12:1] position | [0] expected
  // position = frame*256 + slot*8 + (bit-1)
  localparam int NV = 30;
  localparam logic [37:0] VEC [NV] = '{
    {4'd6,  8'b00000000, 4'b1000, 9'b0_00000_000, 12'd1,   1'b0}, // R6 FAS bit2
    {4'd6,  8'b00000000, 4'b0000, 9'b0_00000_000, 12'd3,   1'b1}, // R6 FAS bit4
    {4'd6,  8'b00000000, 4'b1000, 9'b0_00000_000, 12'd5,   1'b0}, // R6 FAS bit6
    {4'd6,  8'b00000000, 4'b0000, 9'b0_00000_000, 12'd257, 1'b1}, // R6 non-align bit2
    {4'd6,  8'b00000000, 4'b1001, 9'b0_00000_000, 12'd258, 1'b0}, // R6 non-align bit3
    {4'd7,  8'b00000000, 4'b0001, 9'b0_00000_000, 12'd0,   1'b1}, // R7 serial intl
    {4'd7,  8'b00000010, 4'b0001, 9'b0_00000_000, 12'd0,   1'b0}, // R7 reg intl=0
    {4'd7,  8'b00000010, 4'b0000, 9'b1_00000_000, 12'd256, 1'b1}, // R7 reg intl=1
    {4'd8,  8'b00000000, 4'b0001, 9'b0_00000_000, 12'd260, 1'b1}, // R8 serial nat
    {4'd8,  8'b00000100, 4'b0001, 9'b0_10110_000, 12'd260, 1'b0}, // R8 reg nat bit5
    {4'd8,  8'b00000100, 4'b0000, 9'b0_10110_000, 12'd261, 1'b1}, // R8 reg nat bit6
    {4'd8,  8'b00000100, 4'b1001, 9'b0_10110_000, 12'd263, 1'b0}, // R8 reg nat bit8
    {4'd8,  8'b00000100, 4'b0000, 9'b0_00000_000, 12'd4,   1'b1}, // R8 align frame keeps FAS
    {4'd9,  8'b00000000, 4'b1000, 9'b0_00000_000, 12'd128, 1'b0}, // R9 MF nibble
    {4'd9,  8'b00000000, 4'b1000, 9'b0_00000_000, 12'd131, 1'b0}, // R9 MF nibble bit4
    {4'd9,  8'b00000000, 4'b0010, 9'b0_00000_000, 12'd132, 1'b1}, // R9 serial extra
    {4'd9,  8'b00001000, 4'b0010, 9'b0_00000_110, 12'd132, 1'b0}, // R9 reg extra bit5
    {4'd9,  8'b00001000, 4'b0000, 9'b0_00000_110, 12'd134, 1'b1}, // R9 reg extra bit7
    {4'd9,  8'b00001000, 4'b0000, 9'b0_00000_110, 12'd135, 1'b1}, // R9 reg extra bit8
    {4'd9,  8'b00001000, 4'b1000, 9'b0_00000_000, 12'd133, 1'b1}, // R9 bit6 payload
    {4'd10, 8'b00010000, 4'b0100, 9'b0_00000_000, 12'd642, 1'b1}, // R10 sig port
    {4'd10, 8'b00000000, 4'b0100, 9'b0_00000_000, 12'd642, 1'b0}, // R10 sig in stream
    {4'd10, 8'b00110000, 4'b0100, 9'b0_00000_000, 12'd642, 1'b0}, // R10 CCS ignores sig_in
    {4'd10, 8'b00100000, 4'b1000, 9'b0_00000_000, 12'd128, 1'b1}, // R10 CCS no MF nibble
    {4'd11, 8'b01000000, 4'b0000, 9'b0_00000_000, 12'd128, 1'b1}, // R11 frame 0
    {4'd11, 8'b01110000, 4'b0000, 9'b0_00000_000, 12'd642, 1'b1}, // R11 frame 2
    {4'd12, 8'b10000000, 4'b0000, 9'b0_00000_000, 12'd1,   1'b1}, // R12 over FAS
    {4'd5,  8'b00000001, 4'b0000, 9'b0_00000_000, 12'd1,   1'b1}, // R5 frame0 non-align
    {4'd5,  8'b00000001, 4'b1000, 9'b0_00000_000, 12'd257, 1'b0}, // R5 frame1 FAS
    {4'd14, 8'b00000000, 4'b1000, 9'b0_00000_000, 12'd40,  1'b1}  // R14 payload
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic apply(input logic [37:0] v);
    {unframed_ones, ts16_ones, ccs_mode, sel_sig_port, sel_xbit_reg,
     sel_nat_reg, sel_intl_reg, mf_on_nonalign} = v[33:26];
    {ser_in, sig_in, xbit_in, natint_in} = v[25:22];
    {cfg_intl_reg, cfg_nat_reg, cfg_xbit_reg} = v[21:13];
  endtask

  initial begin
    #900000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt_clk, cnt_sig, cnt_mf, cnt_al;

    // R1: reset state and first position after release
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset ser_out", ser_out, 0);
    check("R1 reset mf_start", mf_start, 0);
    check("R1 reset align_frame", align_frame, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 first mf_start", mf_start, 1);
    check("R1 first align_frame", align_frame, 1);
    check("R1 first slot_clk", slot_clk, 1);
    check("R1 first sig_slot", sig_slot, 0);

    // R2 R3 R4: one full multiframe of strobes (positions 0..4095)
    do_reset();
    cnt_clk = 0; cnt_sig = 0; cnt_mf = 0; cnt_al = 0;
    for (int k = 0; k < 4096; k++) begin
      @(posedge clk); #1;
      if (k < 256) cnt_clk += int'(slot_clk);
      cnt_sig += int'(sig_slot);
      cnt_mf  += int'(mf_start);
      cnt_al  += int'(align_frame);
      if (k == 128) check("R3 sig_slot at slot16 bit1", sig_slot, 1);
      if (k == 127) check("R3 sig_slot at slot15 bit8", sig_slot, 0);
      if (k == 4)   check("R2 slot_clk low at bit5", slot_clk, 0);
      if (k == 256) check("R4 frame1 not align", align_frame, 0);
    end
    check("R2 slot_clk highs per frame", cnt_clk, 128);
    check("R3 sig_slot highs per multiframe", cnt_sig, 128);
    check("R4 mf_start highs per multiframe", cnt_mf, 256);
    check("R4 align highs per multiframe", cnt_al, 2048);
    @(posedge clk); #1;
    check("R4 wrap to frame 0", mf_start, 1);

    // Table of single-bit overhead vectors
    for (int i = 0; i < NV; i++) begin
      rst = 1'b1;
      apply(VEC[i]);
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      repeat (int'(VEC[i][12:1]) + 1) @(posedge clk);
      #1;
      check($sformatf("R%0d vector %0d", int'(VEC[i][37:34]), i), int'(ser_out), int'(VEC[i][0]));
    end
    apply('0);

    // R14: one-cycle latency of payload at a single-cycle pulse
    do_reset();
    repeat (40) @(posedge clk);
    #1 ser_in = 1'b1;
    @(posedge clk); #1 ser_in = 1'b0;
    check("R14 latency before", ser_out, 1);
    @(posedge clk); #1;
    check("R14 latency after", ser_out, 0);

    // R13: lone frame sync mid-frame moves to the next frame
    do_reset();
    repeat (100) @(posedge clk);
    #1 fsync_in = 1'b1;
    @(posedge clk); #1;
    check("R13 fsync align_frame", align_frame, 0);
    check("R13 fsync mf_start", mf_start, 0);
    check("R13 fsync slot_clk", slot_clk, 1);
    repeat (127) @(posedge clk); #1;
    check("R13 fsync slot15", sig_slot, 0);
    @(posedge clk); #1;
    check("R13 fsync slot16", sig_slot, 1);
    // R13: multiframe sync while frame sync stays high
    #1 mfsync_in = 1'b1;
    @(posedge clk); #1;
    check("R13 mfsync mf_start", mf_start, 1);
    check("R13 mfsync sig_slot", sig_slot, 0);

    // R13: both edges in one cycle, multiframe wins
    fsync_in = 1'b0; mfsync_in = 1'b0;
    do_reset();
    repeat (300) @(posedge clk);
    #1 fsync_in = 1'b1; mfsync_in = 1'b1;
    @(posedge clk); #1;
    check("R13 both mf_start", mf_start, 1);
    check("R13 both align_frame", align_frame, 1);
    check("R13 both slot_clk", slot_clk, 1);
    repeat (128) @(posedge clk); #1;
    check("R13 both sig_slot after 128", sig_slot, 1);
    check("R13 both still frame 0", mf_start, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule